// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence of a synchronous DRAM burst within one open row of 256 columns. A one-cycle start pulse gives the first column together with the burst length and the burst order. From the next clock onward the block presents one column address per cycle with a valid flag. A last flag marks the final address of a fixed-length burst.

The burst length is 1, 2, 4 or 8 words, or a full page. For fixed lengths the address wraps inside the naturally aligned group of BL columns that holds the start column. The order within that group is either sequential (modulo-BL increment) or interleaved (start XOR count). A full-page burst counts through all 256 columns and keeps wrapping until it is terminated. A terminate input ends any burst early. A new start pulse may arrive on any cycle and restarts the sequence at once.

Top module: `sdr_burst_col`

## Requirements
- R1: While rst_ni is low, and after reset until the first start pulse, valid_o and last_o are 0.
- R2: The block captures blen_i and order_i on the start cycle and uses them for the whole burst. The blen_i codes are 0=1 word, 1=2 words, 2=4 words and 3=8 words; any code with bit 2 set selects full page. For order_i, 0 is sequential and 1 is interleaved.
- R3: Sequential, fixed length BL: the k-th address (k=0..BL-1) has its low log2(BL) bits equal to (start + k) mod BL. Its upper bits equal those of the start column.
- R4: Interleaved, fixed length BL: the k-th address has its low log2(BL) bits equal to start XOR k. Its upper bits equal those of the start column.
- R5: Full page: the k-th address is (start + k) mod 256 and wraps without end. order_i has no effect, and last_o is never 1.
- R6: For a fixed length, last_o is 1 together with the BL-th address. If no start pulse arrives in that cycle, valid_o is 0 in the next cycle.
- R7: A terminate pulse (term_i=1, start_i=0) makes valid_o 0 from the next cycle. If start_i and term_i are 1 together, start_i wins.
- R8: A start pulse on any cycle, including in the middle of a burst, makes the next cycle show valid_o=1 with col_o equal to the new start column.
- R9: Changes of start_col_i, blen_i and order_i in cycles without a start pulse do not affect the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a new burst this cycle |
| start_col_i | input | 8 | First column of the burst |
| blen_i | input | 3 | Burst length code |
| order_i | input | 1 | Burst order: 0 sequential, 1 interleaved |
| term_i | input | 1 | End the running burst |
| col_o | output | 8 | Current column address |
| valid_o | output | 1 | col_o holds a burst address |
| last_o | output | 1 | col_o is the final address of a fixed-length burst |

## Verification
The address state is one counter plus a latched start column and length mask. Any error in these registers shows on col_o, valid_o or last_o in the first cycle after the faulty edge. A wrong count, mask or order flag gives a wrong address at once. A wrong length or end-of-burst decision moves last_o, or leaves valid_o high one cycle too long. Full-page wrap only shows at the 255-to-0 crossing, so the stimulus includes that crossing.

// File: rtl/sdr_bcol_pkg.sv
package sdr_bcol_pkg;
  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bcol_len_decode.sv
module bcol_len_decode #(
  parameter int COL_W = 8,
  parameter int LEN_W = 3
) (
  input  logic [LEN_W-1:0] blen_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o
);
  // top code bit selects full page; lower bits give log2(BL)
  assign full_o = blen_i[LEN_W-1];

  for (genvar g = 0; g < COL_W; g++) begin : g_mask
    assign mask_o[g] = full_o || (int'(blen_i[LEN_W-2:0]) > g);
  end
endmodule

// File: rtl/bcol_seq_ctr.sv
module bcol_seq_ctr #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  output logic [COL_W-1:0] cnt_o,
  output logic             active_o,
  output logic             last_o
);
  logic [COL_W-1:0] cnt_q;
  logic             act_q;

  assign last_o = act_q && !full_i && (cnt_q == mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (term_i) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_o) act_q <= 1'b0;
    end
  end

  assign cnt_o    = cnt_q;
  assign active_o = act_q;
endmodule

// File: rtl/bcol_addr_gen.sv
module bcol_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  input  logic             full_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low;

  always_comb begin
    if (ilv_i && !full_i) low = base_i ^ cnt_i;
    else                  low = base_i + cnt_i;
    col_o = (base_i & ~mask_i) | (low & mask_i);
  end
endmodule

// File: rtl/sdr_burst_col.sv
module sdr_burst_col
  import sdr_bcol_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] blen_i,
  input  logic             order_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] mask_d, mask_q, base_q, cnt;
  logic             full_d, full_q;
  burst_order_e     ord_q;

  bcol_len_decode #(.COL_W(COL_W), .LEN_W(LEN_W)) u_dec (
    .blen_i (blen_i),
    .mask_o (mask_d),
    .full_o (full_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      ord_q  <= ORD_SEQ;
    end else if (start_i) begin
      base_q <= start_col_i;
      mask_q <= mask_d;
      full_q <= full_d;
      ord_q  <= burst_order_e'(order_i);
    end
  end

  bcol_seq_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .term_i   (term_i),
    .mask_i   (mask_q),
    .full_i   (full_q),
    .cnt_o    (cnt),
    .active_o (valid_o),
    .last_o   (last_o)
  );

  bcol_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_i (base_q),
    .cnt_i  (cnt),
    .mask_i (mask_q),
    .ilv_i  (ord_q == ORD_ILV),
    .full_i (full_q),
    .col_o  (col_o)
  );
endmodule

// File: rtl/sdr_burst_col_chk.sv
module sdr_burst_col_chk #(
  parameter int COL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic [COL_W-1:0] mask_q,
  input logic             full_q
);
  // R1
  always_comb if (!rst_ni) a_reset_idle_r1: assert (!valid_o && !last_o);

  p_first_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  p_term_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && !start_i) |=> !valid_o);

  p_last_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o);

  p_last_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  p_full_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && full_q && !start_i && !term_i) |=> (!valid_o || col_o == $past(col_o) + 1'b1));

  p_upper_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i) |=> (!valid_o || ((col_o & ~mask_q) == ($past(col_o) & ~mask_q))));
endmodule

bind sdr_burst_col sdr_burst_col_chk #(.COL_W(COL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .term_i      (term_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .mask_q      (mask_q),
  .full_q      (full_q)
);

// File: tb/sdr_burst_col_test.sv
module sdr_burst_col_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] scol = '0;
  logic [2:0] blen = '0;
  logic       ord = 1'b0;
  logic       term = 1'b0;
  logic [7:0] col;
  logic       valid, last;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  bit       m_act = 0;
  bit       m_full = 0;
  bit       m_ilv = 0;
  int       m_bl = 1;
  int       m_cnt = 0;
  logic [7:0] m_base = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_burst_col uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_col_i(scol),
    .blen_i(blen), .order_i(ord), .term_i(term),
    .col_o(col), .valid_o(valid), .last_o(last)
  );

  function automatic logic [7:0] exp_col();
    logic [7:0] msk, low;
    if (m_full) return m_base + 8'(m_cnt);
    msk = 8'(m_bl - 1);
    low = m_ilv ? (m_base ^ 8'(m_cnt)) : (m_base + 8'(m_cnt));
    return (m_base & ~msk) | (low & msk);
  endfunction

  function automatic bit exp_last();
    return m_act && !m_full && (m_cnt == m_bl - 1);
  endfunction

  task automatic chk(string tag);
    checks++;
    if (valid !== m_act) begin
      errors++;
      $display("FAIL %s valid_o actual=%0b expected=%0b", tag, valid, m_act);
    end
    checks++;
    if (last !== exp_last()) begin
      errors++;
      $display("FAIL %s last_o actual=%0b expected=%0b", tag, last, exp_last());
    end
    if (m_act) begin
      checks++;
      if (col !== exp_col()) begin
        errors++;
        $display("FAIL %s col_o actual=%02h expected=%02h", tag, col, exp_col());
      end
    end
  endtask

  // check current outputs, then drive inputs for the next edge and advance the model
  task automatic step(bit s, logic [7:0] c, logic [2:0] b, bit o, bit t, string tag);
    @(negedge clk);
    chk(tag);
    start = s; scol = c; blen = b; ord = o; term = t;
    if (s) begin
      m_act = 1; m_cnt = 0; m_base = c; m_full = b[2]; m_ilv = o;
      m_bl = 1 << b[1:0];
    end else if (t) begin
      m_act = 0;
    end else if (m_act) begin
      if (exp_last()) m_act = 0;
      m_cnt = m_full ? ((m_cnt + 1) % 256) : (m_cnt + 1);
    end
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 8'($urandom), 3'($urandom), 1'($urandom), 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1");
    rst_n = 1'b1;
    idle(3, "R1");

    // R3: sequential, every fixed length, start column inside the group
    for (int b = 0; b < 4; b++) begin
      step(1, 8'hAD, 3'(b), 0, 0, "R3");
      idle(9, "R3");
    end
    // R4: interleaved
    for (int b = 0; b < 4; b++) begin
      step(1, 8'h5E, 3'(b), 1, 0, "R4");
      idle(9, "R4");
    end
    // R6: back-to-back bursts, start on the last cycle
    step(1, 8'h13, 3'd2, 0, 0, "R6");
    idle(3, "R6");
    step(1, 8'h27, 3'd1, 1, 0, "R6");
    idle(4, "R6");
    // R5: full page across the 255->0 wrap, interleave ignored, then terminate
    step(1, 8'hFD, 3'd4, 1, 0, "R5");
    idle(300, "R5");
    step(0, 8'h00, 3'd0, 0, 1, "R7");
    idle(3, "R7");
    // R7: terminate a fixed burst; start wins over term
    step(1, 8'h40, 3'd3, 0, 0, "R7");
    idle(2, "R7");
    step(0, 8'h00, 3'd0, 0, 1, "R7");
    idle(2, "R7");
    step(1, 8'h88, 3'd3, 1, 1, "R7");
    idle(9, "R7");
    // R8: restart in the middle of a burst
    step(1, 8'h30, 3'd3, 0, 0, "R8");
    idle(3, "R8");
    step(1, 8'hC5, 3'd2, 1, 0, "R8");
    idle(6, "R8");
    // R2: other full-page codes
    step(1, 8'h07, 3'd7, 0, 0, "R2");
    idle(5, "R2");
    step(1, 8'h09, 3'd5, 1, 0, "R2");
    idle(4, "R2");
    step(0, 8'h00, 3'd0, 0, 1, "R2");
    idle(2, "R2");

    // R9: random traffic with mode inputs changing every cycle
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) == 0, 8'($urandom), 3'($urandom), 1'($urandom),
           ($urandom % 24) == 0, "R9");
    end
    idle(3, "R9");

    @(negedge clk);
    chk("R9");
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule